// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Handling

This block turns an asynchronous serial input into characters. A two-flop synchronizer first brings the line into the clock domain. On every oversampling tick (sixteen per bit) the block looks for a falling edge. It confirms the start bit at its centre, then samples five to eight data bits least significant first, an optional parity bit and the stop bit. Each finished character is handed on as a single-cycle strobe. The data is right-justified and travels with three per-character flags: parity error, framing error and break. There is no backpressure, so the buffer that follows must take every strobe.

When the line stays low through a whole frame, stop bit included, the block reports one all-zero character with the break flag set. When the line drops low partway through a character, the damaged character is reported first with its error flags. If the line then stays low for one more full frame time, a second, all-zero character with the break flag follows. After any break report the block waits for the line to stay high for half a bit before it looks for a new start bit.

Top module: `serial_rx_engine`

## Requirements
- R1: A start bit is taken when a tick sees the synchronized line low while idle. It is confirmed eight ticks later, at mid-bit. If the line is high at that point the start is dropped and no character is produced.
- R2: Data bits are sampled every sixteen ticks after the confirmed start, least significant bit first. `charLen` sets the count: 0 selects 5 bits, 1 selects 6, 2 selects 7, 3 selects 8. `charData` holds the bits right-justified, with unused upper bits zero.
- R3: `parMode` 1 selects even parity and 2 selects odd; 0 and 3 mean no parity bit. When the received parity bit disagrees with the data under the selected mode, `parityErr` is 1 with the character, otherwise 0.
- R4: A character whose stop bit is sampled high is reported with `frameErr` 0 and `breakFlag` 0.
- R5: A character whose stop bit is sampled low, and whose data or parity bits are not all zero, is reported with `frameErr` 1 and its received data.
- R6: A frame that is low from the start bit through the stop bit, parity included, is reported as one character: data 0, `breakFlag` 1, `frameErr` 0, `parityErr` 0.
- R7: After a break report the start search resumes only once eight consecutive ticks have seen the line high. A low line before then restarts that count and produces no character.
- R8: After a framing-error character, if the line stays low for a full frame time (start, data, parity and stop bits times sixteen ticks), a second character with data 0 and `breakFlag` 1 follows. If the line goes high earlier, no second character is produced.
- R9: `charValid` is high for exactly one clock per character. While it is low, `charData` and all three flags are zero, which is also their state after reset.
- R10: While `enable` is low the receiver stays idle and produces no character, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling strobe, sixteen per bit time |
| enable | input | 1 | Receiver enable |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| charLen | input | 2 | Character length code (5 + value bits) |
| parMode | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| charValid | output | 1 | One-clock strobe for a finished character |
| charData | output | DATA_W | Received data, right-justified |
| parityErr | output | 1 | Parity error for this character |
| frameErr | output | 1 | Framing error for this character |
| breakFlag | output | 1 | Break character indicator |

## Verification
The stop-bit sample is the one place where two functions meet in a single cycle. A low stop bit fits the framing-error rule, and an all-low frame also fits the break rule, so both decisions are made on the same tick. The bench provokes this with an even-parity frame whose data, parity and stop bits are all zero. It expects exactly one character with the break flag set and the framing and parity flags clear. It contrasts this with frames that carry a set data bit and a low stop bit, which must give the framing-error character, and a break character too only if the line stays low long enough.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRKWAIT,
    S_HIGHWAIT
  } rxState_e;

  // Strobes from control to datapath, all valid on a tick cycle
  typedef struct packed {
    logic clear;      // new frame: wipe shift and parity registers
    logic shiftBit;   // capture a data bit
    logic takePar;    // capture the parity bit
    logic emitChar;   // publish assembled character with flags
    logic emitBreak;  // publish an all-zero break character
  } dpCmd_t;

  function automatic logic parityOn(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction

endpackage

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  dpCmd_t            cmd,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parMode,
  output logic              lineBit,
  output logic              frameZero,
  output logic              charValid,
  output logic [DATA_W-1:0] charData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakFlag
);

  localparam int SH_W = $clog2(DATA_W) + 1;
  localparam int SHIFT_BASE = DATA_W - 5;

  logic [1:0]        syncQ;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] alignedData;
  logic              onesOdd;
  logic              parBad;

  // Two-flop synchronizer, idle-high reset value
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineBit = syncQ[1];

  // LSB-first assembly: new bits enter at the top and move down
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (cmd.clear) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (cmd.shiftBit) shiftReg <= {lineBit, shiftReg[DATA_W-1:1]};
      if (cmd.takePar)  parBit   <= lineBit;
    end
  end

  assign frameZero   = (shiftReg == '0) && !parBit;
  assign shAmt       = SH_W'(SHIFT_BASE) - SH_W'(charLen);
  assign alignedData = shiftReg >> shAmt;
  assign onesOdd     = (^shiftReg) ^ parBit;
  assign parBad      = ((parMode == 2'd1) && onesOdd) ||
                       ((parMode == 2'd2) && !onesOdd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charValid <= 1'b0;
      charData  <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakFlag <= 1'b0;
    end else begin
      charValid <= cmd.emitChar | cmd.emitBreak;
      charData  <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakFlag <= 1'b0;
      if (cmd.emitBreak) begin
        breakFlag <= 1'b1;
      end else if (cmd.emitChar) begin
        charData  <= alignedData;
        parityErr <= parBad;
        frameErr  <= !lineBit;
      end
    end
  end

  AST_BREAK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && breakFlag) |-> (charData == '0 && !frameErr && !parityErr)); // R6

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> !charValid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |-> (charData == '0 && !frameErr && !parityErr && !breakFlag)); // R9

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       lineBit,
  input  logic       frameZero,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  output dpCmd_t     cmd
);

  localparam int CNT_W = $clog2(OVERSAMPLE * (DATA_W + 4));
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVERSAMPLE - 1);

  rxState_e         state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic [IDX_W-1:0] bitIdx, idxNx;
  logic [IDX_W-1:0] lastIdx;
  logic [CNT_W-1:0] frameLast;
  logic             parOn;

  assign parOn     = parityOn(parMode);
  assign lastIdx   = IDX_W'(charLen) + IDX_W'(4);
  // start + (5 + charLen) data + parity + stop, in ticks, minus one
  assign frameLast = CNT_W'((32'd7 + 32'(charLen) + 32'(parOn)) * OVERSAMPLE - 1);

  always_comb begin
    stateNx = state;
    cntNx   = cnt;
    idxNx   = bitIdx;
    cmd     = '0;
    if (!enable) begin
      stateNx = S_IDLE;
      cntNx   = '0;
      idxNx   = '0;
    end else if (tick) begin
      unique case (state)
        S_IDLE: begin
          if (!lineBit) begin
            stateNx   = S_START;
            cntNx     = '0;
            cmd.clear = 1'b1;
          end
        end
        S_START: begin
          if (cnt == HALF_M1) begin
            cntNx   = '0;
            idxNx   = '0;
            stateNx = lineBit ? S_IDLE : S_DATA;
          end else cntNx = cnt + 1'b1;
        end
        S_DATA: begin
          if (cnt == FULL_M1) begin
            cntNx        = '0;
            cmd.shiftBit = 1'b1;
            if (bitIdx == lastIdx) begin
              idxNx   = '0;
              stateNx = parOn ? S_PAR : S_STOP;
            end else idxNx = bitIdx + 1'b1;
          end else cntNx = cnt + 1'b1;
        end
        S_PAR: begin
          if (cnt == FULL_M1) begin
            cntNx       = '0;
            cmd.takePar = 1'b1;
            stateNx     = S_STOP;
          end else cntNx = cnt + 1'b1;
        end
        S_STOP: begin
          if (cnt == FULL_M1) begin
            cntNx = '0;
            if (lineBit) begin
              cmd.emitChar = 1'b1;
              stateNx      = S_IDLE;
            end else if (frameZero) begin
              cmd.emitBreak = 1'b1;
              stateNx       = S_HIGHWAIT;
            end else begin
              cmd.emitChar = 1'b1;
              stateNx      = S_BRKWAIT;
            end
          end else cntNx = cnt + 1'b1;
        end
        S_BRKWAIT: begin
          if (lineBit) begin
            cntNx   = '0;
            stateNx = S_IDLE;
          end else if (cnt == frameLast) begin
            cntNx         = '0;
            cmd.emitBreak = 1'b1;
            stateNx       = S_HIGHWAIT;
          end else cntNx = cnt + 1'b1;
        end
        S_HIGHWAIT: begin
          if (!lineBit) cntNx = '0;
          else if (cnt == HALF_M1) begin
            cntNx   = '0;
            stateNx = S_IDLE;
          end else cntNx = cnt + 1'b1;
        end
        default: begin
          stateNx = S_IDLE;
          cntNx   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNx;
      cnt    <= cntNx;
      bitIdx <= idxNx;
    end
  end

  AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && state == S_START && cnt == HALF_M1 && lineBit) |=> (state == S_IDLE)); // R1

  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && state == S_HIGHWAIT && !lineBit) |=> (state == S_HIGHWAIT && cnt == '0)); // R7

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == S_IDLE)); // R10

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic              rxLine,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parMode,
  output logic              charValid,
  output logic [DATA_W-1:0] charData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakFlag
);

  dpCmd_t cmd;
  logic   lineBit;
  logic   frameZero;

  srx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .lineBit(lineBit), .frameZero(frameZero),
    .charLen(charLen), .parMode(parMode), .cmd(cmd)
  );

  srx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cmd(cmd),
    .charLen(charLen), .parMode(parMode),
    .lineBit(lineBit), .frameZero(frameZero),
    .charValid(charValid), .charData(charData),
    .parityErr(parityErr), .frameErr(frameErr), .breakFlag(breakFlag)
  );

  AST_NO_CHAR_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !charValid); // R10

endmodule

// File: tb/serial_rx_engine_bench.sv
`timescale 1ns/1ps
module serial_rx_engine_bench;

  localparam int CLK_PER_TICK = 4;
  localparam int CLK_PER_BIT  = 16 * CLK_PER_TICK;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic       enable;
  logic       rxLine;
  logic [1:0] charLen;
  logic [1:0] parMode;
  logic       charValid;
  logic [7:0] charData;
  logic       parityErr;
  logic       frameErr;
  logic       breakFlag;

  int   nChecks = 0;
  int   nFail   = 0;
  int   r9Bad   = 0;
  bit   prevValid = 1'b0;
  bit   done = 1'b0;
  logic [10:0] evQ[$];

  always #2 clk = ~clk;

  serial_rx_engine u_serial_rx_engine (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .rxLine(rxLine),
    .charLen(charLen), .parMode(parMode), .charValid(charValid),
    .charData(charData), .parityErr(parityErr), .frameErr(frameErr),
    .breakFlag(breakFlag)
  );

  initial begin
    tick = 1'b0;
    forever begin
      repeat (CLK_PER_TICK - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // Event capture and R9 strobe/quiet monitor
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (charValid) evQ.push_back({breakFlag, frameErr, parityErr, charData});
      if (charValid && prevValid) r9Bad++;
      if (!charValid && (charData != 0 || parityErr || frameErr || breakFlag)) r9Bad++;
      prevValid = charValid;
    end
  end

  function automatic logic [10:0] ev(bit b, bit f, bit p, logic [7:0] d);
    return {b, f, p, d};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic holdLine(logic v, int bits);
    rxLine = v;
    repeat (bits * CLK_PER_BIT) @(negedge clk);
  endtask

  task automatic cfg(int len, logic [1:0] pm);
    charLen = 2'(len - 5);
    parMode = pm;
  endtask

  task automatic sendChar(logic [7:0] d, int n, logic [1:0] pm, bit badPar, logic stopV);
    logic [7:0] m;
    logic p;
    m = 8'hFF >> (8 - n);
    holdLine(1'b0, 1);
    for (int i = 0; i < n; i++) holdLine(d[i], 1);
    if (pm == 2'd1 || pm == 2'd2) begin
      p = ^(d & m);
      if (pm == 2'd2) p = ~p;
      if (badPar) p = ~p;
      holdLine(p, 1);
    end
    holdLine(stopV, 1);
  endtask

  task automatic expectEv(string req, int idx, logic [10:0] exp);
    if (idx < evQ.size()) check(req, $sformatf("event %0d", idx), 32'(evQ[idx]), 32'(exp));
    else check(req, $sformatf("missing event %0d", idx), 32'hDEAD, 32'(exp));
  endtask

  task automatic testReset();
    check("R9", "valid after reset", 32'(charValid), 0);
    check("R9", "data after reset", 32'({charData, parityErr, frameErr, breakFlag}), 0);
  endtask

  task automatic testNormal();
    evQ.delete();
    cfg(8, 2'd0); sendChar(8'hA5, 8, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    cfg(5, 2'd0); sendChar(8'h13, 5, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    cfg(7, 2'd0); sendChar(8'h55, 7, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    cfg(6, 2'd3); sendChar(8'h2A, 6, 2'd3, 0, 1'b1); holdLine(1'b1, 2);
    check("R2", "count", evQ.size(), 4);
    expectEv("R4", 0, ev(0, 0, 0, 8'hA5));
    expectEv("R2", 1, ev(0, 0, 0, 8'h13));
    expectEv("R2", 2, ev(0, 0, 0, 8'h55));
    expectEv("R2", 3, ev(0, 0, 0, 8'h2A));
  endtask

  task automatic testParity();
    evQ.delete();
    cfg(8, 2'd1); sendChar(8'h37, 8, 2'd1, 0, 1'b1); holdLine(1'b1, 2);
    sendChar(8'h37, 8, 2'd1, 1, 1'b1); holdLine(1'b1, 2);
    cfg(6, 2'd2); sendChar(8'h2A, 6, 2'd2, 0, 1'b1); holdLine(1'b1, 2);
    sendChar(8'h2A, 6, 2'd2, 1, 1'b1); holdLine(1'b1, 2);
    check("R3", "count", evQ.size(), 4);
    expectEv("R3", 0, ev(0, 0, 0, 8'h37));
    expectEv("R3", 1, ev(0, 0, 1, 8'h37));
    expectEv("R3", 2, ev(0, 0, 0, 8'h2A));
    expectEv("R3", 3, ev(0, 0, 1, 8'h2A));
  endtask

  task automatic testFalseStart();
    evQ.delete();
    cfg(8, 2'd0);
    rxLine = 1'b0;
    repeat (4 * CLK_PER_TICK) @(negedge clk);
    holdLine(1'b1, 2);
    check("R1", "glitch count", evQ.size(), 0);
    sendChar(8'h81, 8, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    check("R1", "count after glitch", evQ.size(), 1);
    expectEv("R1", 0, ev(0, 0, 0, 8'h81));
  endtask

  task automatic testFraming();
    evQ.delete();
    cfg(8, 2'd0);
    sendChar(8'h3C, 8, 2'd0, 0, 1'b0); holdLine(1'b1, 3);
    check("R5", "count", evQ.size(), 1);
    expectEv("R5", 0, ev(0, 1, 0, 8'h3C));
  endtask

  task automatic testBreak();
    evQ.delete();
    cfg(8, 2'd1);
    sendChar(8'h00, 8, 2'd1, 0, 1'b0);
    holdLine(1'b0, 2);
    rxLine = 1'b1;
    repeat (4 * CLK_PER_TICK) @(negedge clk);
    holdLine(1'b0, 2);
    holdLine(1'b1, 3);
    check("R7", "count before next char", evQ.size(), 1);
    sendChar(8'h5A, 8, 2'd1, 0, 1'b1); holdLine(1'b1, 2);
    check("R6", "count", evQ.size(), 2);
    expectEv("R6", 0, ev(1, 0, 0, 8'h00));
    expectEv("R7", 1, ev(0, 0, 0, 8'h5A));
  endtask

  task automatic testMidBreak();
    evQ.delete();
    cfg(8, 2'd0);
    sendChar(8'h01, 8, 2'd0, 0, 1'b0);
    holdLine(1'b0, 12);
    holdLine(1'b1, 2);
    check("R8", "long break count", evQ.size(), 2);
    expectEv("R8", 0, ev(0, 1, 0, 8'h01));
    expectEv("R8", 1, ev(1, 0, 0, 8'h00));
    evQ.delete();
    sendChar(8'h01, 8, 2'd0, 0, 1'b0);
    holdLine(1'b1, 3);
    check("R8", "short low count", evQ.size(), 1);
    expectEv("R8", 0, ev(0, 1, 0, 8'h01));
  endtask

  task automatic testDisable();
    evQ.delete();
    cfg(8, 2'd0);
    enable = 1'b0;
    sendChar(8'h33, 8, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    check("R10", "disabled count", evQ.size(), 0);
    enable = 1'b1;
    holdLine(1'b1, 1);
    sendChar(8'h44, 8, 2'd0, 0, 1'b1); holdLine(1'b1, 2);
    check("R10", "enabled count", evQ.size(), 1);
    expectEv("R10", 0, ev(0, 0, 0, 8'h44));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b1; rxLine = 1'b1; charLen = 2'd3; parMode = 2'd0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    holdLine(1'b1, 1);
    testNormal();
    testParity();
    testFalseStart();
    testFraming();
    testBreak();
    testMidBreak();
    testDisable();
    check("R9", "strobe width and quiet outputs", r9Bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule